// File: doc/BRIEF.md
# Lock-Gated Descriptor-Chained DMA Channel

This block is one DMA channel that runs a chain of buffer descriptors. A parameter fixes its direction when it is built. In the memory-to-stream direction it reads words from local memory and presents them on an output stream. In the stream-to-memory direction it takes words from an input stream and writes them into local memory. Every descriptor holds these fields:

- a base address and a length in 32-bit words;
- a lock number, with the value the lock must hold before the transfer starts and the value written to the lock afterwards;
- the index of the descriptor that follows, and a flag that marks the end of the chain.

A start command names the first descriptor. For each descriptor the channel waits until the lock bank grants the acquire, moves the words, releases the lock with the descriptor's release value, and then follows the link. Two descriptors that point at each other form an endless ping-pong over two buffers. A consumer elsewhere hands each buffer back by restoring the lock value. The descriptor table has 16 entries, and software loads it through a write port while the channel is idle.

Top module: `dma_bd_chan`

## Requirements
- R1: While reset is held and on the cycle after it, busy, done, lock_req, mem_en, m_out_valid and s_in_ready are all 0.
- R2: A descriptor write (cfg_we) is taken only while busy is 0. A write presented while busy is 1 leaves the table unchanged. A write and a start in the same idle cycle run the newly written contents.
- R3: A start while idle begins the chain at descriptor start_idx. A start while busy has no effect.
- R4: Before each descriptor's transfer, lock_req is 1 with lock_op = 0 (acquire), lock_id = the descriptor's lock and lock_val = its expected value. These hold steady until lock_ack, and no memory access is issued meanwhile.
- R5: After the grant, the channel moves exactly len words at addresses base, base+1, and so on in ascending order. Memory-to-stream drives m_out_data = mem_rdata, with the read returned in the same cycle. Stream-to-memory writes s_in_data with mem_we = 1.
- R6: In a cycle where the stream side stalls (m_out_ready = 0 or s_in_valid = 0), mem_en is 0 and mem_addr keeps its value.
- R7: After the last word, the channel issues lock_req with lock_op = 1 (release), the descriptor's lock and its release value. It issues exactly one such release per descriptor.
- R8: When the end flag is 0, the channel continues with the descriptor named by its next field. A loop of descriptors runs until it stalls on a lock.
- R9: After the release acknowledge of a descriptor whose end flag is 1, done is 1 for exactly one cycle, and busy is 0 in that same cycle.
- R10: A descriptor with length 0 still acquires and releases its lock, but makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor table write strobe |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_base | input | 10 | Descriptor base word address |
| cfg_len | input | 10 | Descriptor length in words |
| cfg_lock | input | 4 | Lock number |
| cfg_acq | input | 2 | Value needed to acquire |
| cfg_rel | input | 2 | Value written on release |
| cfg_next | input | 4 | Index of the following descriptor |
| cfg_last | input | 1 | End-of-chain flag |
| start | input | 1 | Start command |
| start_idx | input | 4 | First descriptor of the chain |
| busy | output | 1 | A chain is running |
| done | output | 1 | One-cycle pulse at the end of the chain |
| lock_req | output | 1 | Lock request |
| lock_op | output | 1 | 0 acquire, 1 release |
| lock_id | output | 4 | Lock number |
| lock_val | output | 2 | Expected value or release value |
| lock_ack | input | 1 | Lock request granted |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |
| s_in_valid | input | 1 | Input stream valid |
| s_in_data | input | 32 | Input stream data |
| s_in_ready | output | 1 | Input stream ready |
| m_out_valid | output | 1 | Output stream valid |
| m_out_data | output | 32 | Output stream data |
| m_out_ready | input | 1 | Output stream ready |

## Verification
A descriptor write and a start command can fall in the same idle cycle. The bench provokes this by first loading a descriptor with one base, then rewriting it with a different base in the very cycle that starts it. The run must stream the words at the new base. The converse also arises: a table write that arrives while a ping-pong loop is running. The bench judges this by checking that later rounds still land at the original base and that the address named in the ignored write is never touched.

// File: rtl/dma_bd_pkg.sv
package dma_bd_pkg;

    localparam int BD_NUM   = 16;
    localparam int BD_IW    = $clog2(BD_NUM);
    localparam int ADDR_W   = 10;
    localparam int LEN_W    = 10;
    localparam int LOCK_NUM = 16;
    localparam int LOCK_IW  = $clog2(LOCK_NUM);
    localparam int LVAL_W   = 2;
    localparam int DATA_W   = 32;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   len;
        logic [LOCK_IW-1:0] lock_id;
        logic [LVAL_W-1:0]  acq_val;
        logic [LVAL_W-1:0]  rel_val;
        logic [BD_IW-1:0]   next;
        logic               last;
    } bd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_MOVE = 2'd2,
        ST_REL  = 2'd3
    } chan_st_e;

    typedef enum logic {
        LK_ACQUIRE = 1'b0,
        LK_RELEASE = 1'b1
    } lock_op_e;

    function automatic logic bd_empty(bd_t b);
        return b.len == '0;
    endfunction

    function automatic logic [LVAL_W-1:0] lock_value(bd_t b, chan_st_e st);
        return (st == ST_REL) ? b.rel_val : b.acq_val;
    endfunction

endpackage

// File: rtl/dma_bd_table.sv
module dma_bd_table
    import dma_bd_pkg::*;
#(
    parameter int NUM = BD_NUM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BD_IW-1:0] wr_idx,
    input  bd_t              wr_bd,
    input  logic [BD_IW-1:0] rd_idx,
    output bd_t              rd_bd
);

    bd_t ent_w [NUM];

    for (genvar e = 0; e < NUM; e++) begin : g_ent
        bd_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_idx == BD_IW'(e))) begin
                q <= wr_bd;
            end
        end
        assign ent_w[e] = q;
    end

    assign rd_bd = ent_w[rd_idx];

endmodule

// File: rtl/dma_bd_seq.sv
module dma_bd_seq
    import dma_bd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BD_IW-1:0]   start_idx,
    input  bd_t                bd,
    input  logic               beat,
    input  logic               lock_ack,
    output logic [BD_IW-1:0]   cur_idx,
    output logic [ADDR_W-1:0]  addr,
    output logic               moving,
    output logic               busy,
    output logic               done,
    output logic               lock_req,
    output logic               lock_op,
    output logic [LOCK_IW-1:0] lock_id,
    output logic [LVAL_W-1:0]  lock_val
);

    chan_st_e          state_q;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BD_IW-1:0]  idx_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= start_idx;
                        state_q <= ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    if (lock_ack) begin
                        addr_q  <= bd.base;
                        left_q  <= bd.len;
                        state_q <= bd_empty(bd) ? ST_REL : ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (beat) begin
                        addr_q <= addr_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == LEN_W'(1)) begin
                            state_q <= ST_REL;
                        end
                    end
                end
                ST_REL: begin
                    if (lock_ack) begin
                        if (bd.last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q   <= bd.next;
                            state_q <= ST_ACQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        lock_req = (state_q == ST_ACQ) || (state_q == ST_REL);
        lock_op  = (state_q == ST_REL) ? LK_RELEASE : LK_ACQUIRE;
        lock_id  = bd.lock_id;
        lock_val = lock_value(bd, state_q);
    end

    assign cur_idx = idx_q;
    assign addr    = addr_q;
    assign moving  = (state_q == ST_MOVE);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;

endmodule

// File: rtl/dma_bd_port.sv
module dma_bd_port
    import dma_bd_pkg::*;
#(
    parameter bit IS_S2MM = 1'b0
) (
    input  logic              moving,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              beat,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] wr_data
);

    if (IS_S2MM) begin : g_s2mm
        logic unused_side;
        assign unused_side = ^{rd_data, out_ready};
        assign in_ready  = moving;
        assign beat      = moving && in_valid;
        assign mem_en    = beat;
        assign mem_we    = beat;
        assign wr_data   = in_data;
        assign out_valid = 1'b0;
        assign out_data  = '0;
    end else begin : g_mm2s
        logic unused_side;
        assign unused_side = ^{in_data, in_valid};
        assign out_valid = moving;
        assign out_data  = rd_data;
        assign beat      = moving && out_ready;
        assign mem_en    = beat;
        assign mem_we    = 1'b0;
        assign wr_data   = '0;
        assign in_ready  = 1'b0;
    end

endmodule

// File: rtl/dma_bd_chan.sv
module dma_bd_chan
    import dma_bd_pkg::*;
#(
    parameter bit IS_S2MM = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [BD_IW-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [LOCK_IW-1:0] cfg_lock,
    input  logic [LVAL_W-1:0]  cfg_acq,
    input  logic [LVAL_W-1:0]  cfg_rel,
    input  logic [BD_IW-1:0]   cfg_next,
    input  logic               cfg_last,
    input  logic               start,
    input  logic [BD_IW-1:0]   start_idx,
    output logic               busy,
    output logic               done,
    output logic               lock_req,
    output logic               lock_op,
    output logic [LOCK_IW-1:0] lock_id,
    output logic [LVAL_W-1:0]  lock_val,
    input  logic               lock_ack,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               s_in_valid,
    input  logic [DATA_W-1:0]  s_in_data,
    output logic               s_in_ready,
    output logic               m_out_valid,
    output logic [DATA_W-1:0]  m_out_data,
    input  logic               m_out_ready
);

    bd_t              wr_bd;
    bd_t              cur_bd;
    logic [BD_IW-1:0] cur_idx;
    logic             moving;
    logic             beat;

    always_comb begin
        wr_bd.base    = cfg_base;
        wr_bd.len     = cfg_len;
        wr_bd.lock_id = cfg_lock;
        wr_bd.acq_val = cfg_acq;
        wr_bd.rel_val = cfg_rel;
        wr_bd.next    = cfg_next;
        wr_bd.last    = cfg_last;
    end

    dma_bd_table #(.NUM(BD_NUM)) i_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && !busy),
        .wr_idx (cfg_idx),
        .wr_bd  (wr_bd),
        .rd_idx (cur_idx),
        .rd_bd  (cur_bd)
    );

    dma_bd_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_idx (start_idx),
        .bd        (cur_bd),
        .beat      (beat),
        .lock_ack  (lock_ack),
        .cur_idx   (cur_idx),
        .addr      (mem_addr),
        .moving    (moving),
        .busy      (busy),
        .done      (done),
        .lock_req  (lock_req),
        .lock_op   (lock_op),
        .lock_id   (lock_id),
        .lock_val  (lock_val)
    );

    dma_bd_port #(.IS_S2MM(IS_S2MM)) i_port (
        .moving    (moving),
        .in_valid  (s_in_valid),
        .in_data   (s_in_data),
        .in_ready  (s_in_ready),
        .out_valid (m_out_valid),
        .out_data  (m_out_data),
        .out_ready (m_out_ready),
        .rd_data   (mem_rdata),
        .beat      (beat),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .wr_data   (mem_wdata)
    );

endmodule

// File: rtl/dma_bd_chan_chk.sv
module dma_bd_chan_chk
    import dma_bd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               lock_req,
    input logic               lock_op,
    input logic [LOCK_IW-1:0] lock_id,
    input logic [LVAL_W-1:0]  lock_val,
    input logic               lock_ack,
    input logic               mem_en,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               s_in_valid,
    input logic               s_in_ready,
    input logic               m_out_valid,
    input logic               m_out_ready
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !lock_req && !mem_en && !m_out_valid && !s_in_ready));

    assert_req_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_req && !lock_ack) |=> (lock_req && $stable(lock_op) && $stable(lock_id) && $stable(lock_val)));

    assert_no_access_in_lock_R4: assert property (@(posedge clk) disable iff (rst)
        lock_req |-> !mem_en);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_write_is_access_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    assert_one_stream_side_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({m_out_valid, s_in_ready}));

    assert_stall_no_access_R6: assert property (@(posedge clk) disable iff (rst)
        ((m_out_valid && !m_out_ready) || (s_in_ready && !s_in_valid)) |-> !mem_en);

    assert_stall_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !lock_req && !mem_en) |=> $stable(mem_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    assert_done_after_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(lock_req && lock_ack && lock_op));

endmodule

bind dma_bd_chan dma_bd_chan_chk i_chk (.*);

// File: tb/test_dma_bd_chan.sv
module tb_env (
    input  logic        clk,
    input  logic        rst,
    input  logic        lock_req,
    input  logic        lock_op,
    input  logic [3:0]  lock_id,
    input  logic [1:0]  lock_val,
    output logic        lock_ack,
    input  logic        mem_en,
    input  logic        mem_we,
    input  logic [9:0]  mem_addr,
    input  logic [31:0] mem_wdata,
    output logic [31:0] mem_rdata,
    input  logic        host_we,
    input  logic [3:0]  host_id,
    input  logic [1:0]  host_val
);
    logic [31:0] mem [0:1023];
    logic [1:0]  lk [0:15];
    int          rel_cnt [0:15];
    int          wr_cnt;

    function automatic logic [31:0] init_word(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
        for (int i = 0; i < 16; i++) begin
            lk[i] = 2'd0;
            rel_cnt[i] = 0;
        end
        wr_cnt = 0;
    end

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst) begin
            lock_ack <= 1'b0;
        end else begin
            lock_ack <= 1'b0;
            if (mem_en && mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (host_we) begin
                lk[host_id] <= host_val;
            end else if (lock_req && !lock_ack) begin
                if (lock_op) begin
                    lk[lock_id] <= lock_val;
                    rel_cnt[lock_id] <= rel_cnt[lock_id] + 1;
                    lock_ack <= 1'b1;
                end else if (lk[lock_id] == lock_val) begin
                    lock_ack <= 1'b1;
                end
            end
        end
    end
endmodule

module test_dma_bd_chan;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit fin   = 0;

    logic        cfg_we_a = 0, cfg_we_b = 0;
    logic [3:0]  cfg_idx = 0, cfg_lock = 0, cfg_next = 0, start_idx = 0;
    logic [9:0]  cfg_base = 0, cfg_len = 0;
    logic [1:0]  cfg_acq = 0, cfg_rel = 0;
    logic        cfg_last = 0;
    logic        start_a = 0, start_b = 0;
    logic        hwe_a = 0, hwe_b = 0;
    logic [3:0]  h_id = 0;
    logic [1:0]  h_val = 0;

    logic        a_busy, a_done, a_lreq, a_lop, a_lack, a_men, a_mwe, a_ovalid, a_iready;
    logic [3:0]  a_lid;
    logic [1:0]  a_lval;
    logic [9:0]  a_maddr;
    logic [31:0] a_wdata, a_rdata, a_odata;
    logic        a_oready = 0;
    logic        b_busy, b_done, b_lreq, b_lop, b_lack, b_men, b_mwe, b_ovalid, b_iready;
    logic [3:0]  b_lid;
    logic [1:0]  b_lval;
    logic [9:0]  b_maddr;
    logic [31:0] b_wdata, b_rdata, b_odata;
    logic        b_ivalid = 0;
    logic [31:0] b_idata = 0;

    dma_bd_chan #(.IS_S2MM(1'b0)) i_dma_bd_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we_a), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_lock(cfg_lock), .cfg_acq(cfg_acq), .cfg_rel(cfg_rel),
        .cfg_next(cfg_next), .cfg_last(cfg_last), .start(start_a), .start_idx(start_idx),
        .busy(a_busy), .done(a_done), .lock_req(a_lreq), .lock_op(a_lop), .lock_id(a_lid),
        .lock_val(a_lval), .lock_ack(a_lack), .mem_en(a_men), .mem_we(a_mwe),
        .mem_addr(a_maddr), .mem_wdata(a_wdata), .mem_rdata(a_rdata),
        .s_in_valid(1'b0), .s_in_data(32'd0), .s_in_ready(a_iready),
        .m_out_valid(a_ovalid), .m_out_data(a_odata), .m_out_ready(a_oready));

    dma_bd_chan #(.IS_S2MM(1'b1)) i_dma_bd_chan_s2mm (
        .clk(clk), .rst(rst), .cfg_we(cfg_we_b), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_lock(cfg_lock), .cfg_acq(cfg_acq), .cfg_rel(cfg_rel),
        .cfg_next(cfg_next), .cfg_last(cfg_last), .start(start_b), .start_idx(start_idx),
        .busy(b_busy), .done(b_done), .lock_req(b_lreq), .lock_op(b_lop), .lock_id(b_lid),
        .lock_val(b_lval), .lock_ack(b_lack), .mem_en(b_men), .mem_we(b_mwe),
        .mem_addr(b_maddr), .mem_wdata(b_wdata), .mem_rdata(b_rdata),
        .s_in_valid(b_ivalid), .s_in_data(b_idata), .s_in_ready(b_iready),
        .m_out_valid(b_ovalid), .m_out_data(b_odata), .m_out_ready(1'b0));

    tb_env env_a (.clk(clk), .rst(rst), .lock_req(a_lreq), .lock_op(a_lop), .lock_id(a_lid),
        .lock_val(a_lval), .lock_ack(a_lack), .mem_en(a_men), .mem_we(a_mwe),
        .mem_addr(a_maddr), .mem_wdata(a_wdata), .mem_rdata(a_rdata),
        .host_we(hwe_a), .host_id(h_id), .host_val(h_val));

    tb_env env_b (.clk(clk), .rst(rst), .lock_req(b_lreq), .lock_op(b_lop), .lock_id(b_lid),
        .lock_val(b_lval), .lock_ack(b_lack), .mem_en(b_men), .mem_we(b_mwe),
        .mem_addr(b_maddr), .mem_wdata(b_wdata), .mem_rdata(b_rdata),
        .host_we(hwe_b), .host_id(h_id), .host_val(h_val));

    logic [31:0] a_cap [$];
    logic [31:0] b_seq = 32'h1000;
    bit          a_hold = 0;

    function automatic logic [31:0] exp_word(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // Stream sides: decide the next-edge handshake at the falling edge.
    always @(negedge clk) begin
        a_oready = a_hold ? 1'b0 : (($urandom % 4) != 0);
        if (a_ovalid && a_oready) a_cap.push_back(a_odata);
        b_ivalid = (($urandom % 3) != 0);
        b_idata  = b_seq;
        if (b_ivalid && b_iready) b_seq = b_seq + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !fin) begin
            fin = 1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_bd(input int idx, input int base, input int len, input int lkn,
                          input int acq, input int rel, input int nxt, input bit last);
        cfg_idx  = 4'(idx);
        cfg_base = 10'(base);
        cfg_len  = 10'(len);
        cfg_lock = 4'(lkn);
        cfg_acq  = 2'(acq);
        cfg_rel  = 2'(rel);
        cfg_next = 4'(nxt);
        cfg_last = last;
    endtask

    task automatic write_bd(input bit to_b, input int idx, input int base, input int len,
                            input int lkn, input int acq, input int rel, input int nxt, input bit last);
        @(negedge clk);
        set_bd(idx, base, len, lkn, acq, rel, nxt, last);
        if (to_b) cfg_we_b = 1; else cfg_we_a = 1;
        @(negedge clk);
        cfg_we_a = 0;
        cfg_we_b = 0;
    endtask

    task automatic kick(input bit to_b, input int idx);
        @(negedge clk);
        start_idx = 4'(idx);
        if (to_b) start_b = 1; else start_a = 1;
        @(negedge clk);
        start_a = 0;
        start_b = 0;
    endtask

    task automatic host_lock(input bit to_b, input int id, input int val);
        @(negedge clk);
        h_id  = 4'(id);
        h_val = 2'(val);
        if (to_b) hwe_b = 1; else hwe_a = 1;
        @(negedge clk);
        hwe_a = 0;
        hwe_b = 0;
    endtask

    task automatic wait_done(input bit to_b, input string tag);
        int t = 0;
        bit seen = 0;
        while (!seen && t < 4000) begin
            @(negedge clk);
            t++;
            seen = to_b ? b_done : a_done;
        end
        check(seen, {tag, " R9 done seen"}, seen, 1);
        check((to_b ? b_busy : a_busy) == 1'b0, {tag, " R9 busy low with done"},
              to_b ? b_busy : a_busy, 0);
        @(negedge clk);
        check((to_b ? b_done : a_done) == 1'b0, {tag, " R9 done one cycle"},
              to_b ? b_done : a_done, 0);
    endtask

    task automatic wait_lock_b(input int id, input int val);
        int t = 0;
        while (env_b.lk[id] != 2'(val) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(env_b.lk[id] == 2'(val), "R8 ping-pong lock released", env_b.lk[id], val);
    endtask

    initial begin
        logic [31:0] expq [$];
        logic [31:0] s0;
        int bad;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset
        check(!a_busy && !a_done && !a_lreq && !a_men && !a_ovalid, "R1 reset A", a_busy, 0);
        check(!b_busy && !b_done && !b_lreq && !b_men && !b_iready, "R1 reset B", b_busy, 0);
        rst = 0;
        @(negedge clk);
        check(!a_busy && !a_lreq && !a_men, "R1 after reset A", a_lreq, 0);

        // R4 R5 R6 R7: single descriptor, lock held off by host
        write_bd(0, 0, 100, 8, 2, 1, 0, 0, 1);
        a_cap.delete();
        a_hold = 1;
        kick(0, 0);
        repeat (8) @(negedge clk);
        check(a_busy == 1, "R3 busy after start", a_busy, 1);
        check(a_lreq == 1 && a_lop == 0, "R4 acquire request", {a_lreq, a_lop}, 2);
        check(a_lid == 4'd2 && a_lval == 2'd1, "R4 acquire lock and value", {a_lid, a_lval}, 9);
        check(a_cap.size() == 0, "R4 no data before grant", a_cap.size(), 0);
        host_lock(0, 2, 1);
        repeat (6) @(negedge clk);
        check(a_ovalid == 1 && a_men == 0, "R6 stalled no access", a_men, 0);
        check(a_maddr == 10'd100, "R6 address held at base", a_maddr, 100);
        a_hold = 0;
        wait_done(0, "single");
        bad = (a_cap.size() != 8) ? 1 : 0;
        for (int i = 0; i < a_cap.size() && i < 8; i++) if (a_cap[i] != exp_word(100 + i)) bad++;
        check(bad == 0, "R5 streamed words", a_cap.size(), 8);
        check(env_a.lk[2] == 2'd0, "R7 release value", env_a.lk[2], 0);
        check(env_a.rel_cnt[2] == 1, "R7 one release", env_a.rel_cnt[2], 1);

        // R2: write and start in the same idle cycle use new contents
        write_bd(0, 6, 500, 2, 6, 0, 1, 0, 1);
        a_cap.delete();
        @(negedge clk);
        set_bd(6, 300, 4, 6, 0, 1, 0, 1);
        cfg_we_a  = 1;
        start_idx = 4'd6;
        start_a   = 1;
        @(negedge clk);
        cfg_we_a = 0;
        start_a  = 0;
        wait_done(0, "same-cycle");
        bad = (a_cap.size() != 4) ? 1 : 0;
        for (int i = 0; i < a_cap.size() && i < 4; i++) if (a_cap[i] != exp_word(300 + i)) bad++;
        check(bad == 0, "R2 new descriptor used", a_cap.size(), 4);
        check(env_a.lk[6] == 2'd1, "R7 release value bd6", env_a.lk[6], 1);

        // R8: random two-descriptor chains
        for (int run = 0; run < 6; run++) begin
            int b1, l1, k1, r1, b2, l2, k2, r2;
            b1 = $urandom % 1000; l1 = 1 + $urandom % 20; k1 = $urandom % 16; r1 = $urandom % 4;
            b2 = $urandom % 1000; l2 = 1 + $urandom % 20; k2 = (k1 + 1 + $urandom % 15) % 16;
            r2 = $urandom % 4;
            write_bd(0, 8, b1, l1, k1, env_a.lk[k1], r1, 9, 0);
            write_bd(0, 9, b2, l2, k2, env_a.lk[k2], r2, 3, 1);
            a_cap.delete();
            expq.delete();
            for (int i = 0; i < l1; i++) expq.push_back(exp_word((b1 + i) % 1024));
            for (int i = 0; i < l2; i++) expq.push_back(exp_word((b2 + i) % 1024));
            kick(0, 8);
            wait_done(0, "random chain");
            bad = (a_cap.size() != expq.size()) ? 1 : 0;
            for (int i = 0; i < a_cap.size() && i < expq.size(); i++) if (a_cap[i] != expq[i]) bad++;
            check(bad == 0, "R8 chained words in order", a_cap.size(), expq.size());
            check(env_a.lk[k1] == 2'(r1) && env_a.lk[k2] == 2'(r2), "R7 chain release values",
                  {env_a.lk[k1], env_a.lk[k2]}, {2'(r1), 2'(r2)});
        end

        // R3 R10: stream-to-memory chain with a zero-length tail
        write_bd(1, 1, 50, 5, 3, 0, 2, 2, 0);
        write_bd(1, 2, 0, 0, 4, 0, 3, 0, 1);
        write_bd(1, 7, 200, 1, 9, 0, 2, 0, 1);
        s0 = b_seq;
        kick(1, 1);
        @(negedge clk);
        kick(1, 7);
        wait_done(1, "s2mm chain");
        bad = 0;
        for (int i = 0; i < 5; i++) if (env_b.mem[50 + i] != s0 + 32'(i)) bad++;
        check(bad == 0, "R5 stream written to memory", bad, 0);
        check(env_b.lk[3] == 2'd2, "R7 s2mm release value", env_b.lk[3], 2);
        check(env_b.lk[4] == 2'd3 && env_b.rel_cnt[4] == 1, "R10 empty bd releases", env_b.lk[4], 3);
        check(env_b.wr_cnt == 5, "R10 empty bd no access", env_b.wr_cnt, 5);
        check(env_b.rel_cnt[9] == 0 && env_b.mem[200] == exp_word(200), "R3 start while busy ignored",
              env_b.rel_cnt[9], 0);

        // R8 R2: endless ping-pong, table write while busy
        write_bd(1, 3, 0, 6, 0, 0, 1, 5, 0);
        write_bd(1, 5, 16, 6, 1, 0, 1, 3, 0);
        s0 = b_seq;
        kick(1, 3);
        for (int r = 0; r < 3; r++) begin
            wait_lock_b(0, 1);
            bad = 0;
            for (int i = 0; i < 6; i++) if (env_b.mem[i] != s0 + 32'(12 * r + i)) bad++;
            check(bad == 0, "R8 ping buffer contents", bad, 0);
            if (r == 0) write_bd(1, 3, 40, 6, 0, 0, 1, 5, 0);
            host_lock(1, 0, 0);
            wait_lock_b(1, 1);
            bad = 0;
            for (int i = 0; i < 6; i++) if (env_b.mem[16 + i] != s0 + 32'(12 * r + 6 + i)) bad++;
            check(bad == 0, "R8 pong buffer contents", bad, 0);
            host_lock(1, 1, 0);
        end
        check(env_b.mem[40] == exp_word(40), "R2 write while busy ignored", env_b.mem[40], exp_word(40));
        check(b_busy == 1, "R8 loop keeps running", b_busy, 1);

        fin = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule